// File: doc/BRIEF.md
# Double-Buffered DAC Input Register

This block is the bus-facing register file in front of a 14-bit digital-to-analog converter. A processor with an 8-bit bus fills a low holding register (code bits 7..0) and a high holding register (code bits 13..8) with separate writes. A third, transfer write then copies both halves into the output register at once, so the converter never sees a half-updated code. A processor with a 16-bit bus can instead load the output register straight from the data pins.

A write is enabled while both active-low inputs, chip select and write, are low. That combined strobe is sampled on the system clock. The write is committed on the first clock edge at which the strobe is seen inactive, so whichever enable rises first ends the write. The committed data and operation are those sampled on the last edge at which the strobe was active. In direct mode the output register also follows the data pins, one clock behind, for as long as the strobe is held.

Top module: `dacr_input_regs`

## Requirements
- R1: A synchronous active-high reset clears the low holding register, the high holding register and the output register to zero.
- R2: Nothing is loaded unless chip select and write are both low together; either enable low on its own leaves every register unchanged.
- R3: Operation code 01 loads data bits 7..0 into the low holding register, and code 10 loads data bits 13..8 into the high holding register; neither changes the output register.
- R4: Operation code 11 copies {high holding, low holding} into the output register in a single clock.
- R5: With operation code 00 and the strobe active, the output register takes the data pins on every clock edge, so the output follows the pins one cycle behind.
- R6: A direct load (code 00) also writes both holding registers, so a following transfer reproduces the same code.
- R7: A write is committed on the first clock edge at which the combined strobe is seen inactive, whether chip select or write rises first; the result is visible after that edge.
- R8: The committed data and operation code are those sampled on the last edge with the strobe active; values on the pins at the release edge are ignored.
- R9: Reset takes priority over a write that is due to commit on the same edge; that write is discarded.
- R10: Two writes separated by a single inactive clock edge both take effect, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_data | input | 14 | Data pins from the processor bus |
| addr_sel | input | 2 | Operation code: 00 direct, 01 low, 10 high, 11 transfer |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write enable, active low |
| dac_code | output | 14 | Output register value driving the converter switches |

## Verification
A commit and a reset can fall on the same clock edge. This happens when the strobe is released in the same cycle that reset is raised. The bench provokes it by releasing a low-register write on the negative edge where it asserts reset. It then judges the result at the ports: the output must read zero, and a later transfer must also give zero, which shows that the pending low byte never reached its holding register. A second overlap is the end of one write meeting the start of the next with only one idle edge between them. The bench checks that both writes land.

// File: rtl/dacr_pkg.sv
package dacr_pkg;

   typedef enum logic [1:0] {
      OP_DIRECT = 2'b00,
      OP_LOW    = 2'b01,
      OP_HIGH   = 2'b10,
      OP_XFER   = 2'b11
   } dacr_op_e;

   function automatic dacr_op_e dacr_decode(input logic [1:0] sel);
      return dacr_op_e'(sel);
   endfunction

endpackage

// File: rtl/dacr_strobe.sv
module dacr_strobe (
   input  logic clk,
   input  logic rst,
   input  logic cs_n,
   input  logic wr_n,
   output logic strobe_live,
   output logic commit
);
   logic strobe_q;

   assign strobe_live = ~cs_n & ~wr_n;

   always_ff @(posedge clk) begin
      if (rst) strobe_q <= 1'b0;
      else     strobe_q <= strobe_live;
   end

   assign commit = strobe_q & ~strobe_live;
endmodule

// File: rtl/dacr_snapshot.sv
module dacr_snapshot
   import dacr_pkg::*;
#(
   parameter int DATA_W = 14
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              strobe_live,
   input  logic [DATA_W-1:0] bus_data,
   input  logic [1:0]        addr_sel,
   output logic [DATA_W-1:0] snap_data,
   output dacr_op_e          snap_op
);
   always_ff @(posedge clk) begin
      if (rst) begin
         snap_data <= '0;
         snap_op   <= OP_DIRECT;
      end else if (strobe_live) begin
         snap_data <= bus_data;
         snap_op   <= dacr_decode(addr_sel);
      end
   end
endmodule

// File: rtl/dacr_hold.sv
module dacr_hold
   import dacr_pkg::*;
#(
   parameter int DATA_W = 14,
   parameter int LO_W   = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              commit,
   input  dacr_op_e          snap_op,
   input  logic [DATA_W-1:0] snap_data,
   output logic [DATA_W-1:0] hold_word
);
   localparam int HI_W    = DATA_W - LO_W;
   localparam int N_LANES = 2;

   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      localparam int       LSB     = (g == 0) ? 0 : LO_W;
      localparam int       WID     = (g == 0) ? LO_W : HI_W;
      localparam dacr_op_e LANE_OP = (g == 0) ? OP_LOW : OP_HIGH;

      logic [WID-1:0] lane_q;
      logic           lane_we;

      assign lane_we = commit && (snap_op == LANE_OP || snap_op == OP_DIRECT);

      always_ff @(posedge clk) begin
         if (rst)          lane_q <= '0;
         else if (lane_we) lane_q <= snap_data[LSB +: WID];
      end

      assign hold_word[LSB +: WID] = lane_q;
   end
endmodule

// File: rtl/dacr_input_regs.sv
module dacr_input_regs
   import dacr_pkg::*;
#(
   parameter int DATA_W        = 14,
   parameter int LO_W          = 8,
   parameter bit DIRECT_FOLLOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] bus_data,
   input  logic [1:0]        addr_sel,
   input  logic              cs_n,
   input  logic              wr_n,
   output logic [DATA_W-1:0] dac_code
);
   localparam int HI_W = DATA_W - LO_W;

   if (LO_W < 1 || HI_W < 1) begin : g_bad_split
      $error("dacr_input_regs: LO_W must lie strictly inside DATA_W");
   end

   logic              strobe_live;
   logic              commit;
   logic [DATA_W-1:0] snap_data;
   dacr_op_e          snap_op;
   logic [DATA_W-1:0] hold_word;
   logic              follow_load;

   dacr_strobe u_strobe (
      .clk         (clk),
      .rst         (rst),
      .cs_n        (cs_n),
      .wr_n        (wr_n),
      .strobe_live (strobe_live),
      .commit      (commit)
   );

   dacr_snapshot #(.DATA_W(DATA_W)) u_snap (
      .clk         (clk),
      .rst         (rst),
      .strobe_live (strobe_live),
      .bus_data    (bus_data),
      .addr_sel    (addr_sel),
      .snap_data   (snap_data),
      .snap_op     (snap_op)
   );

   dacr_hold #(.DATA_W(DATA_W), .LO_W(LO_W)) u_hold (
      .clk       (clk),
      .rst       (rst),
      .commit    (commit),
      .snap_op   (snap_op),
      .snap_data (snap_data),
      .hold_word (hold_word)
   );

   if (DIRECT_FOLLOW) begin : g_follow
      assign follow_load = strobe_live && (dacr_decode(addr_sel) == OP_DIRECT);
   end else begin : g_no_follow
      assign follow_load = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dac_code <= '0;
      end else if (commit) begin
         if (snap_op == OP_DIRECT)    dac_code <= snap_data;
         else if (snap_op == OP_XFER) dac_code <= hold_word;
      end else if (follow_load) begin
         dac_code <= bus_data;
      end
   end
endmodule

// File: rtl/dacr_input_regs_chk.sv
module dacr_input_regs_chk #(
   parameter int DATA_W        = 14,
   parameter bit DIRECT_FOLLOW = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic [DATA_W-1:0] bus_data,
   input logic [1:0]        addr_sel,
   input logic              cs_n,
   input logic              wr_n,
   input logic [DATA_W-1:0] dac_code
);
   logic              live;
   logic              prev_live;
   logic [1:0]        last_addr;
   logic [DATA_W-1:0] last_data;

   assign live = !cs_n && !wr_n;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_live <= 1'b0;
         last_addr <= 2'b00;
         last_data <= '0;
      end else begin
         prev_live <= live;
         if (live) begin
            last_addr <= addr_sel;
            last_data <= bus_data;
         end
      end
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk) rst |=> dac_code == '0);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!live && !prev_live) |=> $stable(dac_code));

   // R3
   hold_only_chk: assert property (@(posedge clk) disable iff (rst)
      (prev_live && !live && (last_addr == 2'b01 || last_addr == 2'b10))
      |=> $stable(dac_code));

   // R7
   direct_commit_chk: assert property (@(posedge clk) disable iff (rst)
      (prev_live && !live && last_addr == 2'b00) |=> dac_code == last_data);

   if (DIRECT_FOLLOW) begin : g_follow_chk
      // R5
      direct_follow_chk: assert property (@(posedge clk) disable iff (rst)
         (live && addr_sel == 2'b00) |=> dac_code == $past(bus_data));
   end
endmodule

bind dacr_input_regs dacr_input_regs_chk #(
   .DATA_W        (DATA_W),
   .DIRECT_FOLLOW (DIRECT_FOLLOW)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .bus_data (bus_data),
   .addr_sel (addr_sel),
   .cs_n     (cs_n),
   .wr_n     (wr_n),
   .dac_code (dac_code)
);

// File: tb/test_dacr_input_regs.sv
`timescale 1ns/1ps
module test_dacr_input_regs;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [13:0] bus_data = '0;
   logic [1:0]  addr_sel = 2'b00;
   logic        cs_n = 1'b1;
   logic        wr_n = 1'b1;
   logic [13:0] dac_code;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [13:0] exp_q[$];
   string       tag_q[$];
   event        chk_ev;

   logic [7:0]  m_lo = '0;
   logic [5:0]  m_hi = '0;
   logic [13:0] m_dac = '0;

   always #4 clk = ~clk;

   dacr_input_regs i_dacr_input_regs (
      .clk(clk), .rst(rst), .bus_data(bus_data), .addr_sel(addr_sel),
      .cs_n(cs_n), .wr_n(wr_n), .dac_code(dac_code)
   );

   // monitor: pops expected items and compares with the output
   initial begin
      forever begin
         @(chk_ev);
         while (exp_q.size() > 0) begin
            logic [13:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (dac_code !== e) begin
               errors++;
               $display("FAIL %s: dac_code=%h expected=%h", t, dac_code, e);
            end
         end
      end
   end

   task automatic expect_now(input logic [13:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      ->chk_ev;
      #0;
   endtask

   task automatic model_apply(input logic [1:0] op, input logic [13:0] d);
      case (op)
         2'b00: begin m_lo = d[7:0]; m_hi = d[13:8]; m_dac = d; end
         2'b01: m_lo = d[7:0];
         2'b10: m_hi = d[13:8];
         default: m_dac = {m_hi, m_lo};
      endcase
   endtask

   // full write: strobe held two edges, released by one enable with junk on pins
   task automatic do_write(input logic [1:0] op, input logic [13:0] d,
                           input bit by_cs, input bit back, input string t);
      if (!back) @(negedge clk);
      addr_sel = op; bus_data = d; cs_n = 1'b0; wr_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      if (by_cs) cs_n = 1'b1; else wr_n = 1'b1;
      bus_data = ~d;
      addr_sel = op ^ 2'b11;
      @(negedge clk);
      model_apply(op, d);
      expect_now(m_dac, t);
      cs_n = 1'b1; wr_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      expect_now(14'h0000, "R1 reset state");

      do_write(2'b01, 14'h00A5, 1'b0, 1'b0, "R3 low load leaves output");
      do_write(2'b10, 14'h2C00, 1'b1, 1'b0, "R3 high load leaves output");
      do_write(2'b11, 14'h0000, 1'b0, 1'b0, "R4 transfer {2C,A5}");
      do_write(2'b01, 14'h3F11, 1'b1, 1'b0, "R3 second low load leaves output");
      do_write(2'b11, 14'h1234, 1'b1, 1'b0, "R4 transfer {2C,11} by cs release R7");

      // R5 direct path follows pins one clock behind
      @(negedge clk);
      addr_sel = 2'b00; bus_data = 14'h3FFF; cs_n = 1'b0; wr_n = 1'b0;
      @(negedge clk);
      expect_now(14'h3FFF, "R5 direct follow first");
      bus_data = 14'h1555;
      @(negedge clk);
      expect_now(14'h1555, "R5 direct follow second");
      wr_n = 1'b1; bus_data = 14'h0AAA; addr_sel = 2'b11;
      @(negedge clk);
      model_apply(2'b00, 14'h1555);
      expect_now(m_dac, "R8 release pins ignored, direct keeps last");
      cs_n = 1'b1;

      do_write(2'b11, 14'h0000, 1'b0, 1'b0, "R6 transfer after direct same code");

      // R2 single enables have no effect
      @(negedge clk);
      addr_sel = 2'b00; bus_data = 14'h0F0F; cs_n = 1'b0; wr_n = 1'b1;
      repeat (3) @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b0; addr_sel = 2'b01;
      repeat (3) @(negedge clk);
      wr_n = 1'b1;
      @(negedge clk);
      expect_now(m_dac, "R2 lone enable output unchanged");
      do_write(2'b11, 14'h0000, 1'b1, 1'b0, "R2 holding untouched by lone enable");

      // R10 back-to-back with one idle edge
      do_write(2'b01, 14'h0000, 1'b0, 1'b0, "R10 first low zero");
      do_write(2'b10, 14'h3FFF, 1'b1, 1'b1, "R10 second high");
      do_write(2'b11, 14'h0000, 1'b0, 1'b1, "R10 third transfer {3F,00}");

      // R7 direct load ended by write release
      do_write(2'b00, 14'h2DB6, 1'b0, 1'b0, "R7 direct by wr release");

      // R9 reset meets pending commit
      @(negedge clk);
      addr_sel = 2'b01; bus_data = 14'h00C3; cs_n = 1'b0; wr_n = 1'b0;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1; rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      m_lo = '0; m_hi = '0; m_dac = '0;
      expect_now(14'h0000, "R9 R1 reset clears output");
      do_write(2'b11, 14'h0000, 1'b0, 1'b0, "R9 pending low discarded");

      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not end, actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule